// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the time-multiplexed drive codes for the common and segment electrodes of a passive segment LCD. It runs from the 32768 Hz reference clock. A 2-bit rate field divides that clock into a slot tick. A 3-bit scheme field chooses how many commons share the glass and which bias ratio is used. Each tick moves the active common forward, and the polarity of the whole frame flips after each pass over the commons so that no net DC is left across a pixel.

Each pin gets a 2-bit level-select code that tells the analog pad which bias rail to connect. Pixels come from a frame buffer that holds four bits per segment. Bit `4*s+k` of the buffer is the pixel of segment `s` under common `k`. One segment, chosen by parameter, can blink on selected commons. A blink mask bit set to 1 blanks that pixel while the external blink phase input reads off.

Top module: `lcd_mux_drv`

## Requirements
- R1: The slot tick period is 2^(BASE_SHIFT+3-clk_sel) reference cycles. With the default BASE_SHIFT of 6, clk_sel 00/01/10/11 give 512/256/128/64 cycles.
- R2: The number of slots in a frame follows mode_sel: 000 gives 4, 001 gives 3, 010 gives 2, 011 gives 3 and 100 gives 1. Codes 101 to 111 behave exactly like 100. The slot index starts at 0, steps by one per tick and wraps after the last slot.
- R3: In one-third bias (modes 000 and 001) with normal polarity, the selected common is 3 and deselected commons are 1. An on segment is 0 and an off segment is 2. Inverted polarity replaces each code c by 3-c.
- R4: In one-half bias (modes 010 and 011) with normal polarity, the selected common is 3, deselected commons are 1, an on segment is 0 and an off segment is 1. Inverted polarity maps 0 to 3 and 3 to 0 and leaves 1 unchanged.
- R5: In static drive (modes 100 to 111) with normal polarity, COM0 is 3, an on segment is 0 and an off segment is 3. Inverted polarity replaces each code c by 3-c.
- R6: Polarity starts normal and toggles at every frame wrap, so each frame is followed by its inverted copy.
- R7: While enable is low, every COM and SEG code is 0 (ground).
- R8: For segment BLINK_SEG, when blink_off is 1 and blink_mask[k] is 1, the pixel under common k is treated as off. Mask bit 3 belongs to COM3 and bit 0 to COM0. All other pixels and segments display the frame buffer unchanged.
- R9: A change of mode_sel or clk_sel while enabled takes effect only at the next frame wrap. While disabled, both fields are taken at once.
- R10: When enable rises, drive begins in slot 0 with normal polarity and a fresh tick count.
- R11: A common whose index is at or above the current slot count is driven to code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Display enable; low grounds all outputs |
| clk_sel | input | 2 | Slot rate select |
| mode_sel | input | 3 | Common count and bias scheme select |
| frame_buf | input | NUM_SEG*4 | Pixel bits, bit 4*s+k = segment s under common k |
| blink_mask | input | 4 | Per-common blink enable for segment BLINK_SEG |
| blink_off | input | 1 | Blink phase: 1 = blinking pixels blanked |
| com_lvl | output | 8 | Level code of COM k at bits 2k+1:2k |
| seg_lvl | output | NUM_SEG*2 | Level code of segment s at bits 2s+1:2s |

## Verification
The bench builds the block with BASE_SHIFT = 1, which gives slot lengths of 16, 8, 4 and 2 cycles, three segments and the blinking segment at index 1. This keeps a full run over every combination of the eight scheme codes and the four rates, each across several polarity-alternating frames, short enough to finish. Under that sweep, a cycle-by-cycle model in the bench compares every output. Directed sequences then cover the slot length for each rate, a scheme change made in mid-frame, restart on enable, and the blink mask against an adjacent segment.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int COMS = 4;

  typedef enum logic [1:0] {
    SCH_THIRD  = 2'd0,
    SCH_HALF   = 2'd1,
    SCH_STATIC = 2'd2
  } sch_e;

  localparam logic [1:0] LV_GND  = 2'd0;
  localparam logic [1:0] LV_LOW  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_FULL = 2'd3;

  // Cycles per slot minus one for a given rate code.
  function automatic int div_limit(int base, logic [1:0] sel);
    return (1 << (base + 3 - int'(sel))) - 1;
  endfunction

  // Commons multiplexed for a scheme code; reserved codes act as static.
  function automatic logic [2:0] ncom_of(logic [2:0] mode);
    case (mode)
      3'b000:  return 3'd4;
      3'b001:  return 3'd3;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic sch_e sch_of(logic [2:0] mode);
    case (mode)
      3'b000, 3'b001: return SCH_THIRD;
      3'b010, 3'b011: return SCH_HALF;
      default:        return SCH_STATIC;
    endcase
  endfunction

  function automatic logic [1:0] com_code(sch_e sch, logic hit, logic pol);
    if (hit) return pol ? LV_GND : LV_FULL;
    case (sch)
      SCH_THIRD: return pol ? LV_HIGH : LV_LOW;
      SCH_HALF:  return LV_LOW;
      default:   return pol ? LV_FULL : LV_GND;
    endcase
  endfunction

  function automatic logic [1:0] seg_code(sch_e sch, logic on, logic pol);
    if (on) return pol ? LV_FULL : LV_GND;
    case (sch)
      SCH_THIRD: return pol ? LV_LOW : LV_HIGH;
      SCH_HALF:  return LV_LOW;
      default:   return pol ? LV_GND : LV_FULL;
    endcase
  endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div
  import lcd_mux_pkg::*;
#(
  parameter int BASE_SHIFT = 6,
  localparam int CNT_W = BASE_SHIFT + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(div_limit(BASE_SHIFT, sel));
  assign tick  = en && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq
  import lcd_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic [2:0] mode_in,
  input  logic [1:0] sel_in,
  output logic [1:0] slot,
  output logic       pol,
  output logic [2:0] mode_q,
  output logic [1:0] sel_q,
  output logic       wrap
);

  logic [1:0] last_slot;

  assign last_slot = 2'(ncom_of(mode_q) - 3'd1);
  assign wrap      = tick && (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      pol    <= 1'b0;
      mode_q <= '0;
      sel_q  <= '0;
    end else if (!en) begin
      slot   <= '0;
      pol    <= 1'b0;
      mode_q <= mode_in;
      sel_q  <= sel_in;
    end else if (wrap) begin
      slot   <= '0;
      pol    <= ~pol;
      mode_q <= mode_in;
      sel_q  <= sel_in;
    end else if (tick) begin
      slot   <= slot + 2'd1;
    end
  end

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG   = 24,
  parameter int BLINK_SEG = 18
) (
  input  logic                 en,
  input  logic [1:0]           slot,
  input  logic                 pol,
  input  logic [2:0]           mode_q,
  input  logic [NUM_SEG*4-1:0] frame_buf,
  input  logic [3:0]           blink_mask,
  input  logic                 blink_off,
  output logic [COMS*2-1:0]    com_lvl,
  output logic [NUM_SEG*2-1:0] seg_lvl
);

  sch_e       sch;
  logic [2:0] ncom;

  assign sch  = sch_of(mode_q);
  assign ncom = ncom_of(mode_q);

  for (genvar i = 0; i < COMS; i++) begin : g_com
    logic active;
    assign active = 3'(i) < ncom;
    assign com_lvl[2*i +: 2] = (en && active)
                               ? com_code(sch, slot == 2'(i), pol) : LV_GND;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic pix;
    if (s == BLINK_SEG) begin : g_blink
      assign pix = frame_buf[4*s + int'(slot)] && !(blink_off && blink_mask[slot]);
    end else begin : g_plain
      assign pix = frame_buf[4*s + int'(slot)];
    end
    assign seg_lvl[2*s +: 2] = en ? seg_code(sch, pix, pol) : LV_GND;
  end

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG    = 24,
  parameter int BLINK_SEG  = 18,
  parameter int BASE_SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [1:0]           clk_sel,
  input  logic [2:0]           mode_sel,
  input  logic [NUM_SEG*4-1:0] frame_buf,
  input  logic [3:0]           blink_mask,
  input  logic                 blink_off,
  output logic [7:0]           com_lvl,
  output logic [NUM_SEG*2-1:0] seg_lvl
);

  logic       slot_tick;
  logic       frame_wrap;
  logic [1:0] slot_q;
  logic       pol_q;
  logic [2:0] mode_q;
  logic [1:0] sel_q;

  lcd_tick_div #(.BASE_SHIFT(BASE_SHIFT)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (enable),
    .sel  (sel_q),
    .tick (slot_tick)
  );

  lcd_slot_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .tick   (slot_tick),
    .mode_in(mode_sel),
    .sel_in (clk_sel),
    .slot   (slot_q),
    .pol    (pol_q),
    .mode_q (mode_q),
    .sel_q  (sel_q),
    .wrap   (frame_wrap)
  );

  lcd_level_map #(.NUM_SEG(NUM_SEG), .BLINK_SEG(BLINK_SEG)) u_map (
    .en        (enable),
    .slot      (slot_q),
    .pol       (pol_q),
    .mode_q    (mode_q),
    .frame_buf (frame_buf),
    .blink_mask(blink_mask),
    .blink_off (blink_off),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
  );

endmodule

// File: rtl/lcd_mux_drv_chk.sv
module lcd_mux_drv_chk
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG    = 24,
  parameter int BASE_SHIFT = 6,
  localparam int CNT_W = BASE_SHIFT + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [7:0]           com_lvl,
  input logic [NUM_SEG*2-1:0] seg_lvl,
  input logic [1:0]           slot,
  input logic                 pol,
  input logic [2:0]           mode_q,
  input logic [1:0]           sel_q,
  input logic                 wrap,
  input logic                 tick
);

  logic [CNT_W-1:0] gap_q;
  logic [3:0]       full_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (!enable || tick)  gap_q <= '0;
    else                       gap_q <= gap_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) full_vec[i] = (com_lvl[2*i +: 2] == LV_FULL);
  end

  // R1
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == CNT_W'(div_limit(BASE_SHIFT, sel_q))));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, slot} < ncom_of(mode_q));

  // R3
  one_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pol) |-> ($countones(full_vec) == 1));

  // R6
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wrap) |=> (!enable || (pol != $past(pol))));

  // R7
  disabled_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (com_lvl == '0 && seg_lvl == '0));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wrap) |=> (!enable || ($stable(mode_q) && $stable(sel_q))));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (slot == 2'd0 && !pol));

endmodule

bind lcd_mux_drv lcd_mux_drv_chk #(.NUM_SEG(NUM_SEG), .BASE_SHIFT(BASE_SHIFT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .com_lvl(com_lvl),
  .seg_lvl(seg_lvl),
  .slot   (slot_q),
  .pol    (pol_q),
  .mode_q (mode_q),
  .sel_q  (sel_q),
  .wrap   (frame_wrap),
  .tick   (slot_tick)
);

// File: tb/lcd_mux_drv_bench.sv
`timescale 1ns/1ps
module lcd_mux_drv_bench;

  localparam int NS  = 3;
  localparam int BS  = 1;
  localparam int BLK = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    clk_sel = '0;
  logic [2:0]    mode_sel = '0;
  logic [NS*4-1:0] frame_buf = '0;
  logic [3:0]    blink_mask = '0;
  logic          blink_off = 1'b0;
  logic [7:0]    com_lvl;
  logic [NS*2-1:0] seg_lvl;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_mux_drv #(.NUM_SEG(NS), .BLINK_SEG(BLK), .BASE_SHIFT(BS)) u_lcd_mux_drv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
    .mode_sel(mode_sel), .frame_buf(frame_buf), .blink_mask(blink_mask),
    .blink_off(blink_off), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // Independent bench model of slot position
  int m_div = 0, m_slot = 0, m_pol = 0, m_mode = 0, m_sel = 0;

  function automatic int slots_in(int md);
    if (md == 0) return 4;
    if (md == 2) return 2;
    if (md == 1 || md == 3) return 3;
    return 1;
  endfunction

  function automatic int slot_len(int s);
    return 16 >> s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_div <= 0; m_slot <= 0; m_pol <= 0;
      m_mode <= int'(mode_sel); m_sel <= int'(clk_sel);
    end else if (m_div == slot_len(m_sel) - 1) begin
      m_div <= 0;
      if (m_slot == slots_in(m_mode) - 1) begin
        m_slot <= 0; m_pol <= 1 - m_pol;
        m_mode <= int'(mode_sel); m_sel <= int'(clk_sel);
      end else m_slot <= m_slot + 1;
    end else m_div <= m_div + 1;
  end

  // kind: 0 third, 1 half, 2 static
  function automatic int kind_of(int md);
    return (md < 2) ? 0 : (md < 4) ? 1 : 2;
  endfunction

  function automatic int flip(int k, int c, int p);
    if (p == 0) return c;
    if (k == 1 && c == 1) return 1;
    return 3 - c;
  endfunction

  function automatic logic [7:0] exp_com();
    logic [7:0] v = '0;
    for (int i = 0; i < 4; i++) begin
      int c;
      if (enable && i < slots_in(m_mode)) begin
        c = (i == m_slot) ? 3 : 1;
        v[2*i +: 2] = 2'(flip(kind_of(m_mode), c, m_pol));
      end
    end
    return v;
  endfunction

  function automatic logic [NS*2-1:0] exp_seg();
    logic [NS*2-1:0] v = '0;
    for (int s = 0; s < NS; s++) begin
      bit on;
      int c, k;
      k  = kind_of(m_mode);
      on = frame_buf[4*s + m_slot];
      if (s == BLK && blink_off && blink_mask[m_slot]) on = 0;
      c = on ? 0 : (k == 0 ? 2 : (k == 1 ? 1 : 3));
      if (enable) v[2*s +: 2] = 2'(flip(k, c, m_pol));
    end
    return v;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_cmp(string tag);
    check(tag, {com_lvl, seg_lvl}, {exp_com(), exp_seg()});
  endtask

  function automatic logic [31:0] mix(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset/disabled state grounds everything
    check("R7 disabled", {com_lvl, seg_lvl}, 0);

    // Sweep every scheme code and rate: R2 R3 R4 R5 R6 R11
    for (int md = 0; md < 8; md++) begin
      for (int sl = 0; sl < 4; sl++) begin
        @(negedge clk);
        enable = 1'b0;
        mode_sel = 3'(md); clk_sel = 2'(sl);
        seed = mix(seed); frame_buf = seed[NS*4-1:0];
        blink_mask = seed[19:16];
        @(negedge clk);
        model_cmp("R7 disabled sweep");
        enable = 1'b1;
        for (int n = 0; n < 3 * 2 * slots_in(md) * slot_len(sl); n++) begin
          @(negedge clk);
          model_cmp(md < 2 ? "R2,R3,R6,R11" : md < 4 ? "R2,R4,R6,R11" : "R2,R5,R6,R11");
          if (n % 5 == 0) begin seed = mix(seed); blink_off = seed[3]; end
          if (n % 7 == 0) frame_buf = frame_buf ^ 12'h5a3;
        end
      end
    end
    blink_off = 1'b0;

    // R1 and R10: slot length per rate, measured from enable rise
    for (int sl = 0; sl < 4; sl++) begin
      int n;
      @(negedge clk);
      enable = 1'b0; mode_sel = 3'b000; clk_sel = 2'(sl);
      @(negedge clk);
      enable = 1'b1;
      #1;
      check("R10 restart slot0", com_lvl[1:0], 3);
      n = 0;
      do begin @(negedge clk); n++; end while (com_lvl[1:0] == 2'd3 && n < 100);
      check("R1 slot length", n, slot_len(sl));
    end

    // R9 and R11: mid-frame scheme change waits for wrap
    @(negedge clk);
    enable = 1'b0; mode_sel = 3'b000; clk_sel = 2'b11;
    @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    mode_sel = 3'b100;
    repeat (2) @(negedge clk);
    check("R9 old scheme COM2 selected", com_lvl[5:4], 3);
    check("R9 old scheme COM0 deselected", com_lvl[1:0], 1);
    repeat (4) @(negedge clk);
    check("R9 new scheme COM0 inverted", com_lvl[1:0], 0);
    check("R11 unused COM1 ground", com_lvl[3:2], 0);
    check("R11 unused COM3 ground", com_lvl[7:6], 0);

    // R8: blink mask on segment BLK, neighbour unaffected
    @(negedge clk);
    enable = 1'b0; mode_sel = 3'b000; clk_sel = 2'b11;
    frame_buf = '1; blink_mask = 4'b0101; blink_off = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    #1;
    check("R8 masked pixel blanked", seg_lvl[2*BLK +: 2], 2);
    check("R8 other segment shown", seg_lvl[1:0], 0);
    blink_off = 1'b0;
    #1;
    check("R8 blink phase on shows pixel", seg_lvl[2*BLK +: 2], 0);
    blink_off = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 unmasked common shown", seg_lvl[2*BLK +: 2], 0);
    repeat (2) @(negedge clk);
    check("R8 mask bit 2 blanked", seg_lvl[2*BLK +: 2], 2);

    // R7: dropping enable grounds outputs at once
    enable = 1'b0;
    #1;
    check("R7 disable mid-frame", {com_lvl, seg_lvl}, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule